// File: doc/BRIEF.md
# Linked-Buffer Stream Capture Engine

This block is a single peripheral-to-memory transfer channel. A source hands it a byte stream, one byte per handshake, with a marker on the last byte of each packet. The engine stores those bytes into memory buffers. Each buffer is described by a four-word record in memory, and each record points to the next one, so the buffers form a chain that software builds before it starts the channel.

Software starts the channel by giving it the address of the first record and the address of a context record. The engine reads the record and fills its buffer one byte at a time. It closes the record when the buffer is full or when a packet ends. On close it writes the real fill end and a packet-end flag back into the record, and it raises raw interrupt bits. It then follows the chain. When it closes a record that is marked as the last in the chain, it writes a disable bit into the context record and stops taking data.

All memory traffic uses one word-wide master port with per-byte write enables. The port holds each request until the memory acknowledges it.

Top module: `dma_stream_in`

## Requirements
- R1: After reset the engine holds in_ready, mem_req, irq_raw, irq_upd and at_eol all low until a start pulse arrives.
- R2: A start pulse reads the four record words at byte offsets +0 (next record address), +4 (buffer start), +8 (flags) and +12 (buffer end). Received bytes are then written to consecutive byte addresses from the buffer start. Each write uses a single byte enable, and the lane is the low two address bits.
- R3: A byte is accepted only while the fill position is below the buffer end. When the position reaches the end, the record closes. A record whose buffer start equals its end closes without taking a byte.
- R4: A byte carrying in_eop closes the record at once. Its +12 word is overwritten with the address one past the last byte stored, and its +8 word is written back with bit 11 set.
- R5: If flags bit 4 is set in a record that closes, irq_raw bits 0 and 1 are both set.
- R6: A close caused by in_eop sets irq_raw bit 3.
- R7: irq_upd is high for exactly those cycles in which irq_raw holds a value different from the cycle before. Bits set in irq_clr clear irq_raw, and a close in the same cycle wins over the clear.
- R8: After write-back of a record with flags bit 0 set, the engine writes 0x00008000 to context address +4, raises at_eol, and keeps in_ready low until the next start.
- R9: After write-back of a record with flags bit 0 clear, the engine reads the record at that record's +0 word. Filling continues at the new record's buffer start.
- R10: in_ready is never high in a cycle in which mem_req is high.
- R11: If the byte that fills the buffer also carries in_eop, the record is closed once. The close has both the packet-end effects (R4, R6) and the full-buffer end value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken while idle or at end of chain |
| start_desc | input | AW | Byte address of the first record |
| start_ctx | input | AW | Byte address of the context record |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_eop | input | 1 | Byte is the last of its packet |
| in_ready | output | 1 | Engine accepts the stream byte |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address (word aligned for word accesses) |
| mem_be | output | 4 | Byte enables of a write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the request |
| irq_clr | input | 4 | Clears the selected raw interrupt bits |
| irq_raw | output | 4 | Raw interrupt status |
| irq_upd | output | 1 | Raw interrupt value changed this cycle |
| at_eol | output | 1 | Chain finished, context disabled |

## Verification
The end of a packet and the filling of a buffer can fall on the same byte. Several vectors place the marked byte exactly at the buffer end. For those vectors the bench expects one close with the full-buffer end address, bit 11 set in the flags word, and irq_raw at 0xB when the record also requests an interrupt. A second coincidence is an interrupt set by a close and an irq_clr pulse on overlapping cycles. The bench counts irq_raw changes against irq_upd pulses over the whole run, and the two counts must match.

// File: rtl/dmain_pkg.sv
package dmain_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_RUN, S_BYTE, S_WB_FLAGS, S_WB_END, S_WB_CTX, S_EOL
  } dmain_state_e;

  // record word indices and flag bit positions
  localparam int W_NEXT = 0;
  localparam int W_BUF  = 1;
  localparam int W_FLAGS = 2;
  localparam int W_END  = 3;
  localparam int F_LAST = 0;
  localparam int F_INTR = 4;
  localparam int F_PEOP = 11;
  localparam int C_DIS  = 15;

  // byte enable for one byte at the given lane
  function automatic logic [3:0] lane_be(input logic [1:0] off);
    return 4'b0001 << off;
  endfunction

  // flags word written back on close
  function automatic logic [31:0] closed_flags(input logic [31:0] f, input logic eop);
    return f | (32'(eop) << F_PEOP);
  endfunction

  // raw interrupt bits raised by one close
  function automatic logic [3:0] close_bits(input logic intr, input logic eop);
    return {eop, 1'b0, intr, intr};
  endfunction

endpackage

// File: rtl/dmain_desc.sv
module dmain_desc #(
  parameter int NW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_en,
  input  logic [$clog2(NW)-1:0] cap_idx,
  input  logic [31:0] cap_word,
  output logic [31:0] words [NW]
);
  for (genvar i = 0; i < NW; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) words[i] <= '0;
      else if (cap_en && cap_idx == i) words[i] <= cap_word;
    end
  end
endmodule

// File: rtl/dmain_irq.sv
module dmain_irq #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_bits,
  input  logic [NB-1:0] clr_bits,
  output logic [NB-1:0] raw,
  output logic          upd
);
  logic [NB-1:0] raw_nxt;
  assign raw_nxt = (raw & ~clr_bits) | set_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw <= '0;
      upd <= 1'b0;
    end else begin
      raw <= raw_nxt;
      upd <= (raw_nxt != raw);
    end
  end
endmodule

// File: rtl/dma_stream_in.sv
module dma_stream_in
  import dmain_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_desc,
  input  logic [AW-1:0] start_ctx,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_eop,
  output logic          in_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic [3:0]    irq_clr,
  output logic [3:0]    irq_raw,
  output logic          irq_upd,
  output logic          at_eol
);
  localparam int NW = 4;
  localparam int IW = $clog2(NW);

  dmain_state_e  state;
  logic [IW-1:0] idx;
  logic [AW-1:0] pos, desc_ptr, ctx_ptr;
  logic [7:0]    byte_q;
  logic          eop_q;
  logic [31:0]   dw [NW];

  logic [AW-1:0] nxt_ptr, buf_ptr, end_ptr;
  logic [31:0]   flags;
  assign nxt_ptr = AW'(dw[W_NEXT]);
  assign buf_ptr = AW'(dw[W_BUF]);
  assign flags   = dw[W_FLAGS];
  assign end_ptr = AW'(dw[W_END]);

  // named internal events
  logic full, close_evt, accept, fetch_cap, fetch_done, wb_last;
  assign full       = (pos >= end_ptr);
  assign close_evt  = (state == S_RUN) && (full || eop_q);
  assign in_ready   = (state == S_RUN) && !full && !eop_q;
  assign accept     = in_valid && in_ready;
  assign fetch_cap  = (state == S_FETCH) && mem_ack;
  assign fetch_done = fetch_cap && (idx == IW'(NW - 1));
  assign wb_last    = (state == S_WB_END) && mem_ack;
  assign at_eol     = (state == S_EOL);

  dmain_desc #(.NW(NW)) u_desc (
    .clk(clk), .rst_n(rst_n), .cap_en(fetch_cap), .cap_idx(idx),
    .cap_word(mem_rdata), .words(dw)
  );

  dmain_irq #(.NB(4)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_bits(close_evt ? close_bits(flags[F_INTR], eop_q) : 4'h0),
    .clr_bits(irq_clr), .raw(irq_raw), .upd(irq_upd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; idx <= '0; pos <= '0;
      desc_ptr <= '0; ctx_ptr <= '0; byte_q <= '0; eop_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_EOL: if (start) begin
          desc_ptr <= start_desc; ctx_ptr <= start_ctx;
          idx <= '0; eop_q <= 1'b0; state <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          idx <= idx + 1'b1;
          if (fetch_done) begin pos <= buf_ptr; state <= S_RUN; end
        end
        S_RUN: begin
          if (close_evt) state <= S_WB_FLAGS;
          else if (accept) begin
            byte_q <= in_data; eop_q <= in_eop; state <= S_BYTE;
          end
        end
        S_BYTE:     if (mem_ack) begin pos <= pos + 1'b1; state <= S_RUN; end
        S_WB_FLAGS: if (mem_ack) state <= S_WB_END;
        S_WB_END: if (wb_last) begin
          if (flags[F_LAST]) state <= S_WB_CTX;
          else begin
            desc_ptr <= nxt_ptr; idx <= '0; eop_q <= 1'b0; state <= S_FETCH;
          end
        end
        S_WB_CTX: if (mem_ack) begin eop_q <= 1'b0; state <= S_EOL; end
        default: state <= S_IDLE;
      endcase
    end
  end

  // memory port
  always_comb begin
    mem_req = 1'b1; mem_we = 1'b1; mem_be = 4'hF;
    mem_addr = '0; mem_wdata = '0;
    case (state)
      S_FETCH: begin
        mem_we = 1'b0;
        mem_addr = desc_ptr + AW'({idx, 2'b00});
      end
      S_BYTE: begin
        mem_addr = {pos[AW-1:2], 2'b00};
        mem_be = lane_be(pos[1:0]);
        mem_wdata = {4{byte_q}};
      end
      S_WB_FLAGS: begin
        mem_addr = desc_ptr + AW'(4 * W_FLAGS);
        mem_wdata = closed_flags(flags, eop_q);
      end
      S_WB_END: begin
        mem_addr = desc_ptr + AW'(4 * W_END);
        mem_wdata = 32'(pos);
      end
      S_WB_CTX: begin
        mem_addr = ctx_ptr + AW'(4);
        mem_wdata = 32'h1 << C_DIS;
      end
      default: begin mem_req = 1'b0; mem_we = 1'b0; mem_be = 4'h0; end
    endcase
  end
endmodule

// File: rtl/dmain_checker.sv
module dmain_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic          mem_ack,
  input logic [3:0]    irq_raw,
  input logic          irq_upd,
  input logic          at_eol,
  input logic          close_evt
);
  assert_ready_no_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_req);

  assert_eol_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    at_eol |-> !in_ready);

  assert_pair_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_raw[0]) |-> irq_raw[1]);

  assert_upd_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_upd |-> (irq_raw != $past(irq_raw)));

  assert_change_has_upd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_raw != $past(irq_raw)) |-> irq_upd);

  assert_partial_write_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1));

  assert_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_single_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> (!close_evt && mem_req && mem_we));
endmodule

bind dma_stream_in dmain_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_ack(mem_ack),
  .irq_raw(irq_raw), .irq_upd(irq_upd), .at_eol(at_eol), .close_evt(close_evt)
);

// File: tb/dma_stream_in_test.sv
module dma_stream_in_test;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 1'b0;
  logic [AW-1:0] start_desc = '0, start_ctx = '0;
  logic in_valid = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, mem_req, mem_we, mem_ack, irq_upd, at_eol;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be, irq_raw;
  logic [3:0] irq_clr = '0;
  logic [31:0] mem_wdata, mem_rdata;

  dma_stream_in #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_desc(start_desc),
    .start_ctx(start_ctx), .in_valid(in_valid), .in_data(in_data),
    .in_eop(in_eop), .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq_clr(irq_clr),
    .irq_raw(irq_raw), .irq_upd(irq_upd), .at_eol(at_eol)
  );

  // memory model: zero-wait, bench writes go through the same port
  logic [31:0] mem [0:255];
  logic tb_we = 1'b0;
  logic [9:0] tb_addr = '0;
  logic [31:0] tb_data = '0;
  assign mem_ack = mem_req;
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) begin
    if (tb_we) mem[tb_addr[9:2]] <= tb_data;
    else if (mem_req && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  int checks = 0, fails = 0;
  int upd_cnt = 0, chg_cnt = 0, r10_bad = 0;
  logic [3:0] prev_raw = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_raw != prev_raw) chg_cnt++;
      if (irq_upd) upd_cnt++;
      if (in_ready && mem_req) r10_bad++;
    end
    prev_raw = irq_raw;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rdb(input int a);
    return mem[a >> 2][8*(a % 4) +: 8];
  endfunction

  task automatic poke(input int a, input logic [31:0] d);
    tb_we = 1'b1; tb_addr = 10'(a); tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic set_rec(input int at, input int nxt, input int b, input int e, input logic [31:0] f);
    poke(at, 32'(nxt)); poke(at + 4, 32'(b)); poke(at + 8, f); poke(at + 12, 32'(e));
  endtask

  task automatic kick(input int d, input int c);
    start_desc = 32'(d); start_ctx = 32'(c); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic e);
    int t = 0;
    in_valid = 1'b1; in_data = d; in_eop = e;
    while (!in_ready && t < 500) begin @(negedge clk); t++; end
    @(negedge clk);
    in_valid = 1'b0; in_eop = 1'b0;
  endtask

  task automatic wait_eol(input string req);
    int t = 0;
    while (!at_eol && t < 500) begin @(negedge clk); t++; end
    chk(req, 32'(at_eol), 32'd1);
  endtask

  task automatic clear_irq();
    irq_clr = 4'hF; @(negedge clk); irq_clr = 4'h0; @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0] boff; logic [7:0] len; logic [7:0] n; logic eop; logic intr;
  } vec_t;
  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{8'd0, 8'd4, 8'd4, 1'b0, 1'b1},
    '{8'd0, 8'd8, 8'd3, 1'b1, 1'b0},
    '{8'd0, 8'd4, 8'd4, 1'b1, 1'b1},
    '{8'd2, 8'd3, 8'd3, 1'b0, 1'b0},
    '{8'd1, 8'd6, 8'd2, 1'b1, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 in_ready", 32'(in_ready), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 irq_raw", 32'(irq_raw), 0);
    chk("R1 at_eol", 32'(at_eol), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {30'd0, in_ready, mem_req}, 0);

    // table of single-record vectors
    for (int v = 0; v < NV; v++) begin
      int b, e, n;
      logic [31:0] f;
      b = 32'h100 + int'(VEC[v].boff);
      e = b + int'(VEC[v].len);
      n = int'(VEC[v].n);
      f = 32'h1 | (32'(VEC[v].intr) << 4);
      for (int w = 0; w < 8; w++) poke(32'h100 + 4*w, 0);
      poke(32'h44, 0);
      set_rec(0, 0, b, e, f);
      kick(0, 32'h40);
      for (int k = 0; k < n; k++)
        push(8'(8'hA0 + 16*v + k), (k == n - 1) && VEC[v].eop);
      wait_eol("R8 at_eol");
      for (int k = 0; k < n; k++)
        chk("R2 byte", 32'(rdb(b + k)), 32'(8'hA0 + 16*v + k));
      chk("R4 R11 end word", mem[3], 32'(VEC[v].eop ? b + n : e));
      chk("R4 flags word", mem[2], f | (32'(VEC[v].eop) << 11));
      chk("R8 ctx word", mem[32'h44 >> 2], 32'h8000);
      chk("R5 R6 R11 irq_raw", 32'(irq_raw),
          32'({VEC[v].eop, 1'b0, VEC[v].intr, VEC[v].intr}));
      // R8 R3 back-pressure after end of chain
      in_valid = 1'b1; in_data = 8'h5A;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        chk("R8 in_ready after eol", 32'(in_ready), 0);
      end
      in_valid = 1'b0;
      @(negedge clk);
      chk("R3 byte past fill", 32'(rdb(b + n)), 0);
      clear_irq();
      chk("R7 cleared", 32'(irq_raw), 0);
    end

    // chained records: early eop in first, full second
    for (int w = 0; w < 16; w++) poke(32'h180 + 4*w, 0);
    poke(32'h44, 0);
    set_rec(32'h00, 32'h20, 32'h180, 32'h184, 32'h0);
    set_rec(32'h20, 32'h0, 32'h1A0, 32'h1A2, 32'h11);
    kick(0, 32'h40);
    push(8'h11, 1'b0);
    push(8'h22, 1'b1);
    push(8'h33, 1'b0);
    push(8'h44, 1'b0);
    wait_eol("R9 chain eol");
    chk("R4 first end", mem[3], 32'h182);
    chk("R4 first flags", mem[2], 32'h800);
    chk("R9 second byte0", 32'(rdb(32'h1A0)), 32'h33);
    chk("R9 second byte1", 32'(rdb(32'h1A1)), 32'h44);
    chk("R9 first untouched", 32'(rdb(32'h182)), 0);
    chk("R9 second end", mem[32'h2C >> 2], 32'h1A2);
    chk("R9 second flags", mem[32'h28 >> 2], 32'h11);
    chk("R6 R5 chain irq", 32'(irq_raw), 32'hB);
    clear_irq();

    // zero-length buffer closes without data
    poke(32'h44, 0);
    set_rec(0, 0, 32'h1C0, 32'h1C0, 32'h1);
    kick(0, 32'h40);
    wait_eol("R3 empty eol");
    chk("R3 empty end", mem[3], 32'h1C0);
    chk("R3 empty flags", mem[2], 32'h1);
    chk("R3 empty irq", 32'(irq_raw), 0);

    // R7 clear of zero bits gives no strobe, totals must match
    irq_clr = 4'h5; @(negedge clk); irq_clr = 4'h0; @(negedge clk);
    chk("R7 upd count", 32'(upd_cnt), 32'(chg_cnt));
    chk("R10 ready during memory", 32'(r10_bad), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule